// File: doc/BRIEF.md
# Self-Delimiting Length-Prefix Field Decoder

The decoder takes a one-bit serial stream, one bit per cycle in which the input is valid, and splits it into fields of any size. Each field opens with a binary length prefix whose own width is not fixed. Every length bit is followed by a flag bit, and a flag of 1 says that the length bit just before it was the final one. The length bits, read most significant first, give the payload size. Exactly that many plain payload bits follow, without flags. The next field starts on the bit right after the last payload bit.

Optionally (parameter `HAS_TYPE`, default 1), each field begins with one extra pair: a type bit and a flag bit. The type bit selects between two payload encodings for logic further down the chain. The flag of that pair is discarded. The decoder reports each closed prefix as a one-cycle length strobe carrying the length and the type. It forwards payload bits with a valid strobe and with flags that mark the first and last bit of the field. A prefix that would need more length bits than the accumulator holds stops the decoder until the next reset.

Top module: `lpd_field_decoder`

## Requirements
- R1: While reset is asserted, and after reset until the stream delivers data, `pay_valid`, `pay_first`, `pay_last`, `len_valid` and `err_overflow` are 0.
- R2: The length prefix is a sequence of accepted pairs: a length bit, then a flag bit. A flag of 1 closes the prefix. The length is the length bits in arrival order, MSB first, with any leading zeros allowed. One cycle after the closing flag is accepted, `len_valid` is 1 for one cycle and `len_value` holds the length. For example, pairs (1,0)(1,0)(0,0)(0,1) give 12, (1,0)(1,0)(0,1) give 6, and (0,0)(1,0)(0,0)(1,1) give 5.
- R3: After a prefix of length N > 0, the next N accepted input bits are payload. Each one appears on `pay_bit` with `pay_valid`=1 in the cycle after it is accepted, in the same order.
- R4: `pay_first`=1 only with the first payload bit of a field, and `pay_last`=1 only with its last. A one-bit payload carries both flags.
- R5: A length of 0 produces the length strobe and no payload bits. The next accepted bit starts the next field.
- R6: Fields follow one another without gaps or separators. A stream of several fields decodes into every field, in order.
- R7: With `HAS_TYPE`=1, each field starts with a type pair (type bit, then a flag). The type bit appears on `fld_type` together with that field's length strobe. The value of the type pair's flag has no effect on decoding.
- R8: The accumulator holds `LEN_W` (default 24) length bits. A prefix of exactly `LEN_W` bits decodes normally. A flag of 0 after the `LEN_W`-th length bit sets `err_overflow` one cycle later. After that, `err_overflow` stays 1 and no further `len_valid` or `pay_valid` appears until reset.
- R9: A cycle with `in_valid`=0 is not consumed: in the following cycle `pay_valid` and `len_valid` are 0 and decoding resumes where it stopped.
- R10: Asserting `rst_n` low clears all outputs, including a set `err_overflow`, without waiting for a clock edge. Reset release takes effect through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_bit | input | 1 | Serial stream bit |
| in_valid | input | 1 | `in_bit` is accepted this cycle |
| pay_bit | output | 1 | Payload bit |
| pay_valid | output | 1 | `pay_bit` is valid |
| pay_first | output | 1 | First payload bit of the field |
| pay_last | output | 1 | Last payload bit of the field |
| len_valid | output | 1 | One-cycle strobe: prefix closed |
| len_value | output | LEN_W | Decoded payload length |
| fld_type | output | 1 | Type bit of the field |
| err_overflow | output | 1 | Sticky prefix-too-long flag |

## Verification
A decoder that loses track of the pair phase, or of the payload count, stays wrong. Every later field reads flags as length bits or payload as prefix, so the very next length strobe shows a wrong value or comes at the wrong time. A remaining-count error shows as a missing or extra `pay_last`, or as payload bits that turn up as spurious length strobes within a few bits. The stimulus therefore mixes random lengths, leading zeros, type values, type-pair flags and idle gaps, and compares every strobe against a model queue. The directed cases cover the maximum prefix width, the overflow case and an asynchronous reset out of the halted state.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

  typedef enum logic [2:0] {
    ST_TYPE  = 3'd0,
    ST_TMARK = 3'd1,
    ST_LBIT  = 3'd2,
    ST_LMARK = 3'd3,
    ST_PAY   = 3'd4,
    ST_HALT  = 3'd5
  } dec_state_e;

endpackage

// File: rtl/lpd_rst_sync.sv
module lpd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/lpd_prefix.sv
module lpd_prefix #(
  parameter int LEN_W = 24,
  localparam int CNT_W = $clog2(LEN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift,
  input  logic             bit_in,
  output logic [LEN_W-1:0] value,
  output logic             full
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LEN_W);

  logic [LEN_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             acc_en;

  always_comb begin
    acc_en = clr | shift;
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    if (clr) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (shift) begin
      acc_d = {acc_q[LEN_W-2:0], bit_in};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign value = acc_q;
  assign full  = (cnt_q == CNT_MAX);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R8

  AST_NO_SHIFT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !shift); // R8

endmodule

// File: rtl/lpd_payload.sv
module lpd_payload #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             take,
  input  logic             bit_in,
  output logic             last_now,
  output logic             pay_bit,
  output logic             pay_valid,
  output logic             pay_first,
  output logic             pay_last
);

  logic [LEN_W-1:0] remain_q, remain_d;
  logic             fpend_q, fpend_d;
  logic             cnt_en;
  logic             pb_q, pb_d;
  logic             pv_q, pv_d;
  logic             pf_q, pf_d;
  logic             pl_q, pl_d;

  assign last_now = (remain_q == LEN_W'(1));

  always_comb begin
    cnt_en   = load | take;
    remain_d = remain_q;
    fpend_d  = fpend_q;
    pb_d     = pb_q;
    pv_d     = 1'b0;
    pf_d     = 1'b0;
    pl_d     = 1'b0;
    if (load) begin
      remain_d = load_len;
      fpend_d  = 1'b1;
    end else if (take) begin
      remain_d = remain_q - 1'b1;
      fpend_d  = 1'b0;
      pb_d     = bit_in;
      pv_d     = 1'b1;
      pf_d     = fpend_q;
      pl_d     = last_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      fpend_q  <= 1'b0;
    end else if (cnt_en) begin
      remain_q <= remain_d;
      fpend_q  <= fpend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_q <= 1'b0;
      pv_q <= 1'b0;
      pf_q <= 1'b0;
      pl_q <= 1'b0;
    end else begin
      pb_q <= pb_d;
      pv_q <= pv_d;
      pf_q <= pf_d;
      pl_q <= pl_d;
    end
  end

  assign pay_bit   = pb_q;
  assign pay_valid = pv_q;
  assign pay_first = pf_q;
  assign pay_last  = pl_q;

  AST_TAKE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (remain_q != '0)); // R3

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_len != '0)); // R5

endmodule

// File: rtl/lpd_ctrl.sv
module lpd_ctrl
  import lpd_pkg::*;
#(
  parameter int LEN_W    = 24,
  parameter bit HAS_TYPE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_bit,
  input  logic             in_valid,
  input  logic [LEN_W-1:0] pfx_value,
  input  logic             pfx_full,
  input  logic             pay_last_now,
  output logic             pfx_clr,
  output logic             pfx_shift,
  output logic             pay_load,
  output logic             pay_take,
  output logic             len_valid,
  output logic [LEN_W-1:0] len_value,
  output logic             fld_type,
  output logic             err_overflow
);

  localparam dec_state_e START = HAS_TYPE ? ST_TYPE : ST_LBIT;

  dec_state_e       state_q, state_d;
  logic             type_q, type_d;
  logic             lv_q, lv_d;
  logic [LEN_W-1:0] lval_q, lval_d;
  logic             ftype_q, ftype_d;
  logic             err_q, err_d;

  always_comb begin
    state_d   = state_q;
    type_d    = type_q;
    lv_d      = 1'b0;
    lval_d    = lval_q;
    ftype_d   = ftype_q;
    err_d     = err_q;
    pfx_clr   = 1'b0;
    pfx_shift = 1'b0;
    pay_load  = 1'b0;
    pay_take  = 1'b0;
    if (in_valid) begin
      case (state_q)
        ST_TYPE: begin
          type_d  = in_bit;
          state_d = ST_TMARK;
        end
        ST_TMARK: begin
          state_d = ST_LBIT;
        end
        ST_LBIT: begin
          pfx_shift = 1'b1;
          state_d   = ST_LMARK;
        end
        ST_LMARK: begin
          if (in_bit) begin
            lv_d    = 1'b1;
            lval_d  = pfx_value;
            ftype_d = type_q;
            pfx_clr = 1'b1;
            if (pfx_value == '0) begin
              state_d = START;
            end else begin
              pay_load = 1'b1;
              state_d  = ST_PAY;
            end
          end else if (pfx_full) begin
            err_d   = 1'b1;
            state_d = ST_HALT;
          end else begin
            state_d = ST_LBIT;
          end
        end
        ST_PAY: begin
          pay_take = 1'b1;
          if (pay_last_now) state_d = START;
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= START;
      type_q  <= 1'b0;
      lv_q    <= 1'b0;
      lval_q  <= '0;
      ftype_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      type_q  <= type_d;
      lv_q    <= lv_d;
      lval_q  <= lval_d;
      ftype_q <= ftype_d;
      err_q   <= err_d;
    end
  end

  assign len_valid    = lv_q;
  assign len_value    = lval_q;
  assign fld_type     = ftype_q;
  assign err_overflow = err_q;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |=> (state_q == ST_HALT)); // R8

  AST_TAKE_ONLY_IN_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    pay_take |-> (state_q == ST_PAY)); // R3

endmodule

// File: rtl/lpd_field_decoder.sv
module lpd_field_decoder #(
  parameter int LEN_W    = 24,
  parameter bit HAS_TYPE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_bit,
  input  logic             in_valid,
  output logic             pay_bit,
  output logic             pay_valid,
  output logic             pay_first,
  output logic             pay_last,
  output logic             len_valid,
  output logic [LEN_W-1:0] len_value,
  output logic             fld_type,
  output logic             err_overflow
);

  logic             rst_sync_n;
  logic             pfx_clr;
  logic             pfx_shift;
  logic [LEN_W-1:0] pfx_value;
  logic             pfx_full;
  logic             pay_load;
  logic             pay_take;
  logic             pay_last_now;

  lpd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpd_prefix #(.LEN_W(LEN_W)) u_prefix (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (pfx_clr),
    .shift  (pfx_shift),
    .bit_in (in_bit),
    .value  (pfx_value),
    .full   (pfx_full)
  );

  lpd_payload #(.LEN_W(LEN_W)) u_payload (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (pay_load),
    .load_len  (pfx_value),
    .take      (pay_take),
    .bit_in    (in_bit),
    .last_now  (pay_last_now),
    .pay_bit   (pay_bit),
    .pay_valid (pay_valid),
    .pay_first (pay_first),
    .pay_last  (pay_last)
  );

  lpd_ctrl #(.LEN_W(LEN_W), .HAS_TYPE(HAS_TYPE)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .in_bit       (in_bit),
    .in_valid     (in_valid),
    .pfx_value    (pfx_value),
    .pfx_full     (pfx_full),
    .pay_last_now (pay_last_now),
    .pfx_clr      (pfx_clr),
    .pfx_shift    (pfx_shift),
    .pay_load     (pay_load),
    .pay_take     (pay_take),
    .len_valid    (len_valid),
    .len_value    (len_value),
    .fld_type     (fld_type),
    .err_overflow (err_overflow)
  );

  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pay_first || pay_last) |-> pay_valid); // R4

  AST_QUIET_WITHOUT_INPUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(in_valid) |-> !(pay_valid || len_valid)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_overflow |=> err_overflow); // R8

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_overflow |-> !(pay_valid || len_valid)); // R8

  AST_LEN_NOT_WITH_PAY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    len_valid |-> !pay_valid); // R2

endmodule

// File: tb/lpd_field_decoder_tb.sv
module lpd_field_decoder_tb;

  localparam int LEN_W = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_bit = 1'b0;
  logic             in_valid = 1'b0;
  logic             pay_bit, pay_valid, pay_first, pay_last;
  logic             len_valid, fld_type, err_overflow;
  logic [LEN_W-1:0] len_value;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit gaps = 1'b0;
  bit done = 1'b0;

  int exp_len[$];
  int exp_typ[$];
  int exp_pay[$];

  always #5 clk = ~clk;

  lpd_field_decoder #(.LEN_W(LEN_W), .HAS_TYPE(1'b1)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_bit       (in_bit),
    .in_valid     (in_valid),
    .pay_bit      (pay_bit),
    .pay_valid    (pay_valid),
    .pay_first    (pay_first),
    .pay_last     (pay_last),
    .len_valid    (len_valid),
    .len_value    (len_value),
    .fld_type     (fld_type),
    .err_overflow (err_overflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int min_bits(input int len);
    int n = 1;
    while ((len >> n) != 0) n++;
    return n;
  endfunction

  function automatic int pay_code(input bit b, input bit f, input bit l);
    return {29'd0, f, l, b};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drive_bit(input bit b);
    @(negedge clk);
    in_bit   = b;
    in_valid = 1'b1;
    if (gaps && ($urandom_range(0, 3) == 0)) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic send_field(input bit typ, input bit tflag, input int len, input int lz);
    int nb;
    int tot;
    bit pb[$];
    nb  = min_bits(len);
    tot = nb + lz;
    exp_len.push_back(len);
    exp_typ.push_back(int'(typ));
    for (int i = 0; i < len; i++) begin
      bit b;
      b = 1'($urandom_range(0, 1));
      pb.push_back(b);
      exp_pay.push_back(pay_code(b, i == 0, i == len - 1));
    end
    drive_bit(typ);
    drive_bit(tflag);
    for (int k = tot - 1; k >= 0; k--) begin
      drive_bit(1'((len >> k) & 1));
      drive_bit(k == 0);
    end
    for (int i = 0; i < len; i++) drive_bit(pb[i]);
  endtask

  task automatic drain();
    idle(4);
    check(exp_len.size() == 0 && exp_pay.size() == 0, "R6", "undelivered items",
          exp_len.size() + exp_pay.size(), 0);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if ((pay_valid || len_valid) && !in_valid)
        check(1'b0, "R9", "output after idle cycle", 1, 0);
      if (len_valid) begin
        if (exp_len.size() == 0) begin
          check(1'b0, "R8", "unexpected length strobe", int'(len_value), -1);
        end else begin
          int el, et;
          el = exp_len.pop_front();
          et = exp_typ.pop_front();
          check(int'(len_value) == el, (el == 0) ? "R5" : "R2", "len_value",
                int'(len_value), el);
          check(int'(fld_type) == et, "R7", "fld_type", int'(fld_type), et);
        end
      end
      if (pay_valid) begin
        if (exp_pay.size() == 0) begin
          check(1'b0, "R3", "unexpected payload bit", int'(pay_bit), -1);
        end else begin
          int ep;
          ep = exp_pay.pop_front();
          check(int'(pay_bit) == (ep & 1), "R3", "pay_bit", int'(pay_bit), ep & 1);
          check({pay_first, pay_last} == 2'(ep >> 1), "R4", "first/last flags",
                int'({pay_first, pay_last}), (ep >> 1) & 3);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    check({pay_valid, len_valid, err_overflow} == 3'b000, "R1", "outputs in reset",
          int'({pay_valid, len_valid, err_overflow}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({pay_valid, pay_first, pay_last, len_valid, err_overflow} == 5'b0, "R1",
          "outputs after reset", int'({pay_valid, len_valid, err_overflow}), 0);

    // directed: example lengths 12, 6, 5 (leading zero), then 0, 1, 3 back to back
    send_field(1'b0, 1'b0, 12, 0);
    send_field(1'b1, 1'b1, 6, 0);
    send_field(1'b0, 1'b1, 5, 1);
    send_field(1'b1, 1'b0, 0, 0);   // R5 zero length
    send_field(1'b0, 1'b0, 0, 2);   // R5 zero length, leading zeros
    send_field(1'b1, 1'b0, 1, 0);   // R4 single bit carries both flags
    send_field(1'b0, 1'b1, 3, 0);
    send_field(1'b1, 1'b1, 1, LEN_W - 1);  // R8 full-width prefix accepted
    drain();
    check(err_overflow == 1'b0, "R8", "full-width prefix flagged", int'(err_overflow), 0);

    // random stream with idle gaps (R9) and random type flags (R7)
    gaps = 1'b1;
    for (int f = 0; f < 60; f++) begin
      int len;
      len = ($urandom_range(0, 4) == 0) ? $urandom_range(0, 2) : $urandom_range(0, 70);
      send_field(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), len,
                 $urandom_range(0, 3));
    end
    gaps = 1'b0;
    drain();

    // overflow: LEN_W length bits, flag 0 after the last one
    drive_bit(1'b1);
    drive_bit(1'b0);
    for (int k = 0; k < LEN_W; k++) begin
      drive_bit(1'b1);
      drive_bit(1'b0);
    end
    idle(2);
    check(err_overflow == 1'b1, "R8", "err_overflow after long prefix", int'(err_overflow), 1);
    for (int k = 0; k < 20; k++) drive_bit(k[0]);  // monitor flags any output
    idle(3);
    check(err_overflow == 1'b1, "R8", "err_overflow sticky", int'(err_overflow), 1);

    // asynchronous reset away from the clock edge
    @(posedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    check(err_overflow == 1'b0, "R10", "err cleared asynchronously", int'(err_overflow), 0);
    check({pay_valid, len_valid} == 2'b00, "R10", "valids cleared", int'({pay_valid, len_valid}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_field(1'b1, 1'b0, 9, 0);
    send_field(1'b0, 1'b0, 2, 1);
    drain();
    check(err_overflow == 1'b0, "R10", "decoder recovered", int'(err_overflow), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule